// File: doc/BRIEF.md
# Sensor Measurement Cycle Sequencer

This block is the control state machine of a low-power light sensor. It holds the sensor in a sleep state until a start condition shows up on its serial bus. It then moves through an idle check, an optional wait period, a one-step init phase and a programmable integration period. Time runs on an external step tick: one tick is one base step of about 2.73 ms. Integration and wait lengths come from 8-bit codes counted in two's complement, so a larger code gives a shorter period. A long-wait option stretches every wait step by a factor of twelve.

The converter is not part of this block. The sequencer only marks where an integration starts (`integ_start`) and where it finishes (`conv_done`); the result registers load on the finish strobe. Around the sequencer, a threshold comparator reports on `irq_gen` whether the finished conversion raised an interrupt. With sleep-after-interrupt set, that interrupt sends the machine back to sleep. Otherwise the cycle repeats on its own while power and measurement stay enabled.

Top module: `meas_cycle_seq`

## Requirements
- R1: After reset the state output reads 0 (sleep), and `integ_start`, `conv_done` and `valid` are low. Sleep is held whatever the enable bits are, until `bus_start` is high at a clock edge.
- R2: Sleep with `bus_start` moves to idle (state 1). Idle with `pwr_on` low moves back to sleep on the next clock.
- R3: Idle with `pwr_on` and `meas_en` both high moves to wait (state 2) when `wait_en` is high, and to init (state 3) otherwise. Idle with `pwr_on` high and `meas_en` low stays in idle.
- R4: Init ends on its first `step_tick`. `integ_start` is high in that cycle, and the next state is integration (state 4). Without a tick, init holds and `integ_start` stays low.
- R5: Integration lasts 256 minus `integ_code` ticks (0xFF gives 1, 0x00 gives 256). `conv_done` is high for one cycle, in the cycle of the final tick, and the state leaves integration on that edge.
- R6: Wait lasts 256 minus `wait_code` ticks, multiplied by 12 when `long_wait` is high. The code and the long-wait bit are taken when wait is entered.
- R7: After `conv_done` the machine enters idle. With `pwr_on` and `meas_en` still high it starts the next cycle by itself.
- R8: If `irq_gen` and `sai_en` are both high in the `conv_done` cycle, the next state is sleep instead of idle.
- R9: Clearing `meas_en` or `pwr_on` in wait, init or integration ends the cycle with no `conv_done`. The next state is idle when `pwr_on` is high and sleep when it is low.
- R10: `valid` rises on the clock edge that ends the first integration after `meas_en` is set. It stays high while `meas_en` stays high and clears on the clock after `meas_en` goes low.
- R11: `bus_start` has no effect outside sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_tick | input | 1 | One-cycle pulse per base time step |
| bus_start | input | 1 | Start condition detected on the serial bus |
| pwr_on | input | 1 | Power-on enable |
| meas_en | input | 1 | Measurement enable |
| wait_en | input | 1 | Insert wait period before each measurement |
| sai_en | input | 1 | Sleep after an interrupt |
| long_wait | input | 1 | Wait steps are 12 base steps long |
| integ_code | input | 8 | Integration length code, two's complement steps |
| wait_code | input | 8 | Wait length code, two's complement steps |
| irq_gen | input | 1 | Interrupt raised by the finished conversion |
| state_o | output | 3 | Current state: 0 sleep, 1 idle, 2 wait, 3 init, 4 integration |
| integ_start | output | 1 | Strobe at the start of integration |
| conv_done | output | 1 | Strobe at the end of integration, loads results |
| valid | output | 1 | A conversion has completed since measurement enable |

## Verification
Two things can fall in the same cycle and compete for the next state: the final integration tick, which ends the cycle with `conv_done`, and the drop of an enable, which cancels the cycle. The bench produces the second alone by clearing `meas_en` in a long wait and by clearing `pwr_on` part-way through a 256-step integration. It then expects no finish strobe and expects the return state chosen by `pwr_on`. The finish tick meeting `irq_gen` is produced with `sai_en` set and with it clear, and the result is judged by whether the next state is sleep or idle.

// File: rtl/meas_seq_pkg.sv
package meas_seq_pkg;

  typedef enum logic [2:0] {
    ST_SLEEP = 3'd0,
    ST_IDLE  = 3'd1,
    ST_WAIT  = 3'd2,
    ST_INIT  = 3'd3,
    ST_INTEG = 3'd4
  } seq_state_e;

  // Number of base steps a two's complement code stands for.
  function automatic int unsigned code_steps(input int unsigned code,
                                             input int unsigned code_w);
    return (32'd1 << code_w) - code;
  endfunction

  // Base ticks in a wait period, with the optional long multiplier.
  function automatic int unsigned wait_ticks(input int unsigned code,
                                             input int unsigned code_w,
                                             input bit          long_en,
                                             input int unsigned mult);
    return code_steps(code, code_w) * (long_en ? mult : 32'd1);
  endfunction

endpackage

// File: rtl/seq_step_timer.sv
module seq_step_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       remain <= '0;
    else if (load)                    remain <= load_val;
    else if (tick && remain != '0)    remain <= remain - CNT_W'(1);
  end

  assign expire = tick && (remain == CNT_W'(1));
endmodule

// File: rtl/seq_valid_flag.sv
module seq_valid_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (clr)  flag <= 1'b0;
    else if (set)  flag <= 1'b1;
  end
endmodule

// File: rtl/meas_cycle_seq.sv
module meas_cycle_seq
  import meas_seq_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int LONG_MULT = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_tick,
  input  logic              bus_start,
  input  logic              pwr_on,
  input  logic              meas_en,
  input  logic              wait_en,
  input  logic              sai_en,
  input  logic              long_wait,
  input  logic [CODE_W-1:0] integ_code,
  input  logic [CODE_W-1:0] wait_code,
  input  logic              irq_gen,
  output logic [2:0]        state_o,
  output logic              integ_start,
  output logic              conv_done,
  output logic              valid
);
  localparam int STEP_SPAN = 1 << CODE_W;
  localparam int CNT_W     = $clog2(STEP_SPAN * LONG_MULT + 1);

  seq_state_e       state, nxt;
  logic             abort_w;
  logic             expire_w;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic [CNT_W-1:0] wait_len;
  logic [CNT_W-1:0] integ_len;
  seq_state_e       abort_dest;

  assign abort_w    = !(pwr_on && meas_en);
  assign abort_dest = pwr_on ? ST_IDLE : ST_SLEEP;
  assign wait_len   = CNT_W'(wait_ticks(32'(wait_code), CODE_W, long_wait, LONG_MULT));
  assign integ_len  = CNT_W'(code_steps(32'(integ_code), CODE_W));

  always_comb begin
    nxt         = state;
    tmr_load    = 1'b0;
    tmr_val     = '0;
    integ_start = 1'b0;
    conv_done   = 1'b0;
    unique case (state)
      ST_SLEEP: if (bus_start) nxt = ST_IDLE;
      ST_IDLE: begin
        if (!pwr_on) nxt = ST_SLEEP;
        else if (meas_en) begin
          tmr_load = 1'b1;
          if (wait_en) begin
            nxt     = ST_WAIT;
            tmr_val = wait_len;
          end else begin
            nxt     = ST_INIT;
            tmr_val = CNT_W'(1);
          end
        end
      end
      ST_WAIT: begin
        if (abort_w) nxt = abort_dest;
        else if (expire_w) begin
          nxt      = ST_INIT;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(1);
        end
      end
      ST_INIT: begin
        if (abort_w) nxt = abort_dest;
        else if (expire_w) begin
          nxt         = ST_INTEG;
          tmr_load    = 1'b1;
          tmr_val     = integ_len;
          integ_start = 1'b1;
        end
      end
      ST_INTEG: begin
        if (abort_w) nxt = abort_dest;
        else if (expire_w) begin
          conv_done = 1'b1;
          nxt       = (irq_gen && sai_en) ? ST_SLEEP : ST_IDLE;
        end
      end
      default: nxt = ST_SLEEP;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_SLEEP;
    else        state <= nxt;
  end

  seq_step_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .tick     (step_tick),
    .expire   (expire_w)
  );

  seq_valid_flag u_valid (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (conv_done),
    .clr   (!meas_en),
    .flag  (valid)
  );

  assign state_o = state;
endmodule

// File: rtl/meas_cycle_seq_chk.sv
module meas_cycle_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] state_o,
  input logic       bus_start,
  input logic       pwr_on,
  input logic       meas_en,
  input logic       sai_en,
  input logic       irq_gen,
  input logic       integ_start,
  input logic       conv_done,
  input logic       valid
);
  a_r1_sleep_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd0 && !bus_start) |=> state_o == 3'd0);

  a_r2_idle_unpowered: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'd1 && !pwr_on) |=> state_o == 3'd0);

  a_r4_start_enters_integ: assert property (@(posedge clk) disable iff (!rst_n)
    integ_start |=> state_o == 3'd4);

  a_r5_done_leaves_integ: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> state_o != 3'd4);

  a_r5_strobes_apart: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({integ_start, conv_done}));

  a_r8_sleep_after_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_done && irq_gen && sai_en) |=> state_o == 3'd0);

  a_r9_abort_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_o == 3'd2 || state_o == 3'd3 || state_o == 3'd4) && pwr_on && !meas_en)
      |=> state_o == 3'd1);

  a_r10_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(conv_done));
endmodule

bind meas_cycle_seq meas_cycle_seq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .state_o     (state_o),
  .bus_start   (bus_start),
  .pwr_on      (pwr_on),
  .meas_en     (meas_en),
  .sai_en      (sai_en),
  .irq_gen     (irq_gen),
  .integ_start (integ_start),
  .conv_done   (conv_done),
  .valid       (valid)
);

// File: tb/tb_meas_cycle_seq.sv
module tb_meas_cycle_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       step_tick = 1'b1, bus_start = 1'b0, pwr_on = 1'b0, meas_en = 1'b0;
  logic       wait_en = 1'b0, sai_en = 1'b0, long_wait = 1'b0, irq_gen = 1'b0;
  logic [7:0] integ_code = 8'hFF, wait_code = 8'hFF;
  logic [2:0] state_o;
  logic       integ_start, conv_done, valid;

  int n_cmp = 0;
  int n_bad = 0;
  int wd    = 0;

  always #5 clk = ~clk;

  meas_cycle_seq dut (
    .clk(clk), .rst_n(rst_n), .step_tick(step_tick), .bus_start(bus_start),
    .pwr_on(pwr_on), .meas_en(meas_en), .wait_en(wait_en), .sai_en(sai_en),
    .long_wait(long_wait), .integ_code(integ_code), .wait_code(wait_code),
    .irq_gen(irq_gen), .state_o(state_o), .integ_start(integ_start),
    .conv_done(conv_done), .valid(valid)
  );

  // fields: wait_en, long_wait, wait_code, integ_code, wait cycles, integ cycles
  localparam int NV = 5;
  localparam logic [38:0] VEC [NV] = '{
    {1'b0, 1'b0, 8'hFF, 8'hFF, 12'd0,   9'd1},
    {1'b1, 1'b0, 8'hFF, 8'hF6, 12'd1,   9'd10},
    {1'b1, 1'b1, 8'hFE, 8'hFF, 12'd24,  9'd1},
    {1'b1, 1'b0, 8'hC0, 8'h00, 12'd64,  9'd256},
    {1'b1, 1'b1, 8'hF0, 8'hFD, 12'd192, 9'd3}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    #1;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      n_bad++;
      $display("FAIL watchdog all-reqs actual=%0d expected=finish", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int nw, ni, ng, nd, dpos, starts, v0;
    // reset state, R1
    repeat (3) cyc();
    chk("R1 reset state", state_o, 0);
    chk("R1 reset valid", valid, 0);
    chk("R1 reset strobes", {integ_start, conv_done}, 0);
    rst_n = 1'b1;
    pwr_on = 1'b1; meas_en = 1'b1;
    repeat (4) cyc();
    chk("R1 sleep held without bus start", state_o, 0);
    // R2: wake with power off
    meas_en = 1'b0; pwr_on = 1'b0; bus_start = 1'b1;
    cyc(); bus_start = 1'b0;
    chk("R2 wake to idle", state_o, 1);
    cyc();
    chk("R2 unpowered idle to sleep", state_o, 0);
    // R3: powered idle without measurement
    pwr_on = 1'b1; bus_start = 1'b1;
    cyc(); bus_start = 1'b0;
    repeat (3) cyc();
    chk("R3 idle held without meas_en", state_o, 1);
    // R11: bus start in idle ignored
    bus_start = 1'b1; cyc(); bus_start = 1'b0; cyc();
    chk("R11 bus_start ignored in idle", state_o, 1);

    // vector table: R3 R5 R6 R7 R10
    for (int k = 0; k < NV; k++) begin
      wait_en = VEC[k][38]; long_wait = VEC[k][37];
      wait_code = VEC[k][36:29]; integ_code = VEC[k][28:21];
      meas_en = 1'b1;
      nw = 0; ni = 0; ng = 0; nd = 0; dpos = 0; starts = 0; v0 = -1;
      for (int c = 0; c < 5000; c++) begin
        cyc();
        if (v0 < 0) v0 = valid;
        if (state_o == 3'd2) nw++;
        if (state_o == 3'd3) begin ni++; if (integ_start) starts++; end
        if (state_o == 3'd4) begin ng++; if (conv_done) begin nd++; dpos = ng; end end
        if (state_o == 3'd1 && ng > 0) break;
      end
      chk("R6 wait length", nw, int'(VEC[k][20:9]));
      chk("R4 init length", ni, 1);
      chk("R4 integ_start count", starts, 1);
      chk("R5 integration length", ng, int'(VEC[k][8:0]));
      chk("R5 done on final tick", dpos, int'(VEC[k][8:0]));
      chk("R5 single done", nd, 1);
      chk("R10 valid low before done", v0, 0);
      chk("R7 idle after done", state_o, 1);
      chk("R10 valid after done", valid, 1);
      meas_en = 1'b0;
      cyc();
      chk("R10 valid clears", valid, 0);
    end

    // R4: init waits for a tick
    wait_en = 1'b0; integ_code = 8'hFF; step_tick = 1'b0; meas_en = 1'b1;
    cyc();
    repeat (3) cyc();
    chk("R4 init held without tick", state_o, 3);
    chk("R4 no start without tick", integ_start, 0);
    step_tick = 1'b1; #1;
    chk("R4 start on tick", integ_start, 1);
    cyc();
    chk("R4 integration after init", state_o, 4);
    chk("R5 one-step done", conv_done, 1);
    cyc();
    // R7: automatic repeat
    cyc();
    chk("R7 next cycle starts", state_o, 3);
    meas_en = 1'b0; cyc();
    chk("R9 abort init to idle", state_o, 1);

    // R9: abort in wait by meas_en
    wait_en = 1'b1; wait_code = 8'h00; long_wait = 1'b0; meas_en = 1'b1;
    repeat (3) cyc();
    chk("R9 in wait", state_o, 2);
    meas_en = 1'b0; #1;
    chk("R9 no done on abort", conv_done, 0);
    cyc();
    chk("R9 wait abort to idle", state_o, 1);

    // R9: abort in integration by pwr_on
    wait_en = 1'b0; integ_code = 8'h00; meas_en = 1'b1;
    repeat (5) cyc();
    chk("R9 in integration", state_o, 4);
    pwr_on = 1'b0; #1;
    chk("R9 no done on power drop", conv_done, 0);
    cyc();
    chk("R9 power drop to sleep", state_o, 0);
    chk("R10 valid stays low after abort", valid, 0);

    // R8: sleep after interrupt
    meas_en = 1'b0; pwr_on = 1'b1; bus_start = 1'b1; cyc(); bus_start = 1'b0;
    integ_code = 8'hFF; sai_en = 1'b1; irq_gen = 1'b1; meas_en = 1'b1;
    cyc(); cyc();
    chk("R8 done with irq", conv_done, 1);
    cyc();
    chk("R8 sleep after irq", state_o, 0);
    // R8: irq without sai returns to idle
    sai_en = 1'b0; bus_start = 1'b1; cyc(); bus_start = 1'b0;
    cyc(); cyc();
    chk("R8 done without sai", conv_done, 1);
    cyc();
    chk("R8 idle without sai", state_o, 1);
    meas_en = 1'b0; cyc();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule